// File: doc/BRIEF.md
# Prioritized Fault Recognition Controller

This block collects fault requests from the rest of a processor and decides which one is taken next, and in which cycle the processor may enter its fault cycle. Each of up to 32 fault numbers has a fixed priority and a fixed timing group. The group decides which condition must hold before entry. Depending on the group, entry is immediate, waits for the memory controller to acknowledge the last access, waits for the current instruction to finish, or is held until an instruction pair completes. The block issues a one-cycle entry strobe together with the winning fault number and its trap vector address.

Requests are single-cycle pulses. A request that cannot be taken yet is remembered in a pending set until its group's condition is met. The datapath that aborts, closes out or completes the instruction lies outside this block. This block only supplies the decision and its timing.

Top module: `fault_recog_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every remembered request. During and after reset, fault_enter is 0, fault_num is 0 and trap_vec is 0.
- R2: fault_enter pulses high in the clock cycle after the cycle in which the winning request and its group condition are presented. fault_num and trap_vec are loaded only on entry and hold between entries, with trap_vec equal to twice fault_num.
- R3: Among the eligible faults, the winner follows this order, strongest first, by fault number: 12, 15, 31, 11, 7, 14, 13, 9, 5, 1, 2, 21, 22, 23, 6, 10, 3, 24, 25, 16, 17, 18, 19, 20, 8, 4, 0.
- R4: Group 1 (numbers 12, 15) and group 2 (numbers 11, 31) faults are taken immediately, whatever the state of mem_ack, insn_done, pair_done and the cycle type (other than the fault cycle).
- R5: Group 3 faults (numbers 13, 14) are taken only in a cycle with mem_ack high. Until then they remain pending.
- R6: Group 4 faults (numbers 1, 5, 7, 9) are taken only in a cycle with both mem_ack and insn_done high.
- R7: Group 5 faults (numbers 2, 3, 6, 10, 21 to 25) and group 6 faults (numbers 16 to 20) need mem_ack. In addition, they need either insn_done or the execute cycle type (cycle_kind = 1). A fault seen during execution therefore treats the instruction as complete.
- R8: A group 5 or 6 fault cannot be taken while any group 1 to 4 fault is pending or requested. When a group 1 to 4 fault is taken, every pending group 5 or 6 fault is discarded.
- R9: Group 7 faults (numbers 0, 4, 8) are taken only in a cycle with pair_done high and g7_inhibit low. Otherwise they are held.
- R10: Requests on fault numbers 26 to 30 are ignored. They never win, never produce an entry and are not remembered.
- R11: No entry occurs while cycle_kind = 2 (fault cycle). Requests stay pending and are taken once the cycle type changes. Cycle codes: 0 fetch, 1 execute, 2 fault, 3 other.
- R12: With no pending or requested fault, fault_enter stays low. Each entry removes only the taken fault from the pending set, apart from the discard in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_req | input | 32 | One request pulse per fault number |
| cycle_kind | input | 2 | Current cycle type: 0 fetch, 1 execute, 2 fault, 3 other |
| insn_done | input | 1 | Current instruction completes this cycle |
| pair_done | input | 1 | Instruction pair completes this cycle |
| g7_inhibit | input | 1 | Inhibit bit from the instruction word, blocks group 7 |
| mem_ack | input | 1 | Memory controller has acknowledged the last access |
| fault_enter | output | 1 | One-cycle fault-cycle entry strobe |
| fault_num | output | 5 | Number of the fault taken |
| trap_vec | output | 6 | Trap vector address, twice fault_num |

## Verification
The hardest situation to reach from the ports is the discard of a lower-group fault. A group 5 or 6 fault must be held back by a group 4 fault that is itself waiting for instruction completion, and the group 5 or 6 fault must then disappear when the group 4 fault is taken. The bench reaches this by raising both requests in an execute cycle with mem_ack high and insn_done low, then opening insn_done, then checking that no second entry follows. A sweep over every pair of fault numbers with all conditions open covers the whole priority order and the discard for every group combination, including the unassigned numbers. Directed sequences then close each group's condition in turn and confirm that the fault is held rather than lost.

// File: rtl/fr_pkg.sv
// Package: shared types and the fixed per-fault attribute table.
// Assumes fault numbers beyond the table are unassigned (group 0).
package fr_pkg;

    localparam int NUM_FAULTS = 32;
    localparam int PRIO_W     = 5;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_EXEC  = 2'd1,
        CYC_FAULT = 2'd2,
        CYC_OTHER = 2'd3
    } cyc_t;

    typedef struct packed {
        logic [2:0]        grp;   // 0 = unassigned, 1..7 timing group
        logic [PRIO_W-1:0] prio;  // lower value wins
    } fattr_t;

    // Returns the group and the priority of a fault number.
    function automatic fattr_t fault_attr(input int n);
        fattr_t a;
        case (n)
            0:  a = '{grp: 3'd7, prio: 5'd27};
            1:  a = '{grp: 3'd4, prio: 5'd10};
            2:  a = '{grp: 3'd5, prio: 5'd11};
            3:  a = '{grp: 3'd5, prio: 5'd17};
            4:  a = '{grp: 3'd7, prio: 5'd26};
            5:  a = '{grp: 3'd4, prio: 5'd9};
            6:  a = '{grp: 3'd5, prio: 5'd15};
            7:  a = '{grp: 3'd4, prio: 5'd5};
            8:  a = '{grp: 3'd7, prio: 5'd25};
            9:  a = '{grp: 3'd4, prio: 5'd8};
            10: a = '{grp: 3'd5, prio: 5'd16};
            11: a = '{grp: 3'd2, prio: 5'd4};
            12: a = '{grp: 3'd1, prio: 5'd1};
            13: a = '{grp: 3'd3, prio: 5'd7};
            14: a = '{grp: 3'd3, prio: 5'd6};
            15: a = '{grp: 3'd1, prio: 5'd2};
            16: a = '{grp: 3'd6, prio: 5'd20};
            17: a = '{grp: 3'd6, prio: 5'd21};
            18: a = '{grp: 3'd6, prio: 5'd22};
            19: a = '{grp: 3'd6, prio: 5'd23};
            20: a = '{grp: 3'd6, prio: 5'd24};
            21: a = '{grp: 3'd5, prio: 5'd12};
            22: a = '{grp: 3'd5, prio: 5'd13};
            23: a = '{grp: 3'd5, prio: 5'd14};
            24: a = '{grp: 3'd5, prio: 5'd18};
            25: a = '{grp: 3'd5, prio: 5'd19};
            31: a = '{grp: 3'd2, prio: 5'd3};
            default: a = '{grp: 3'd0, prio: 5'd31};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/fr_classify.sv
// Module: fr_classify
// Derives constant per-fault masks from the attribute table: assigned
// numbers, the high groups (1..4) and the discardable groups (5, 6).
// Assumes the table in fr_pkg; no state.
module fr_classify #(
    parameter int N_FLT = fr_pkg::NUM_FAULTS
) (
    output logic [N_FLT-1:0] assigned_m,
    output logic [N_FLT-1:0] hi_m,
    output logic [N_FLT-1:0] mid_m
);
    for (genvar i = 0; i < N_FLT; i++) begin : g_cls
        localparam logic [2:0] GRP = fr_pkg::fault_attr(i).grp;
        // Constant mask bits for fault number i.
        assign assigned_m[i] = (GRP != 3'd0);
        assign hi_m[i]       = (GRP >= 3'd1) && (GRP <= 3'd4);
        assign mid_m[i]      = (GRP == 3'd5) || (GRP == 3'd6);
    end
endmodule

// File: rtl/fr_gate.sv
// Module: fr_gate
// Applies each fault's group entry condition to the candidate set.
// Assumes candidates are already limited to assigned numbers.
module fr_gate #(
    parameter int N_FLT = fr_pkg::NUM_FAULTS
) (
    input  logic [N_FLT-1:0] cand,
    input  logic [1:0]       cycle_kind,
    input  logic             hi_pending,
    input  logic             insn_done,
    input  logic             pair_done,
    input  logic             g7_inhibit,
    input  logic             mem_ack,
    output logic [N_FLT-1:0] elig
);
    logic in_exec, in_fault;

    // Decode of the cycle type.
    assign in_exec  = (cycle_kind == fr_pkg::CYC_EXEC);
    assign in_fault = (cycle_kind == fr_pkg::CYC_FAULT);

    for (genvar i = 0; i < N_FLT; i++) begin : g_gate
        localparam logic [2:0] GRP = fr_pkg::fault_attr(i).grp;
        logic open_c;
        // Group-specific readiness for fault number i.
        always_comb begin
            case (GRP)
                3'd1, 3'd2: open_c = 1'b1;
                3'd3:       open_c = mem_ack;
                3'd4:       open_c = mem_ack & insn_done;
                3'd5, 3'd6: open_c = mem_ack & (in_exec | insn_done) & ~hi_pending;
                3'd7:       open_c = pair_done & ~g7_inhibit;
                default:    open_c = 1'b0;
            endcase
        end
        // Eligible when requested, ready and outside the fault cycle.
        assign elig[i] = cand[i] & open_c & ~in_fault;
    end
endmodule

// File: rtl/fr_select.sv
// Module: fr_select
// Picks the eligible fault with the lowest priority value.
// Assumes priority values are unique among assigned numbers.
module fr_select #(
    parameter int N_FLT = fr_pkg::NUM_FAULTS,
    localparam int NUM_W = $clog2(N_FLT)
) (
    input  logic [N_FLT-1:0] elig,
    output logic             win_valid,
    output logic [NUM_W-1:0] win_num
);
    logic [fr_pkg::PRIO_W-1:0] best;

    // Linear minimum search over all eligible faults.
    always_comb begin
        win_valid = 1'b0;
        win_num   = '0;
        best      = '1;
        for (int i = 0; i < N_FLT; i++) begin
            if (elig[i] && (!win_valid || fr_pkg::fault_attr(i).prio < best)) begin
                win_valid = 1'b1;
                best      = fr_pkg::fault_attr(i).prio;
                win_num   = NUM_W'(i);
            end
        end
    end
endmodule

// File: rtl/fault_recog_ctrl.sv
// Module: fault_recog_ctrl (top)
// Remembers fault requests, applies group timing rules, selects the
// winner and issues a registered fault-cycle entry with number and
// trap vector. Assumes single-cycle request pulses; synchronous
// active-low reset.
module fault_recog_ctrl #(
    parameter int N_FLT = fr_pkg::NUM_FAULTS,
    localparam int NUM_W = $clog2(N_FLT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_FLT-1:0] fault_req,
    input  logic [1:0]       cycle_kind,
    input  logic             insn_done,
    input  logic             pair_done,
    input  logic             g7_inhibit,
    input  logic             mem_ack,
    output logic             fault_enter,
    output logic [NUM_W-1:0] fault_num,
    output logic [NUM_W:0]   trap_vec
);
    logic [N_FLT-1:0] assigned_m, hi_m, mid_m;
    logic [N_FLT-1:0] pend, cand, elig, win_oh;
    logic             hi_pending, win_valid;
    logic [NUM_W-1:0] win_num;

    fr_classify #(.N_FLT(N_FLT)) u_cls (
        .assigned_m(assigned_m), .hi_m(hi_m), .mid_m(mid_m)
    );

    // Candidates: new pulses plus remembered faults, assigned numbers only.
    assign cand       = (fault_req | pend) & assigned_m;
    assign hi_pending = |(cand & hi_m);

    fr_gate #(.N_FLT(N_FLT)) u_gate (
        .cand(cand), .cycle_kind(cycle_kind), .hi_pending(hi_pending),
        .insn_done(insn_done), .pair_done(pair_done),
        .g7_inhibit(g7_inhibit), .mem_ack(mem_ack), .elig(elig)
    );

    fr_select #(.N_FLT(N_FLT)) u_sel (
        .elig(elig), .win_valid(win_valid), .win_num(win_num)
    );

    assign win_oh = N_FLT'(1) << win_num;

    // Pending set: drop the winner, and lower groups after a high-group win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (win_valid)
            pend <= cand & ~win_oh & (hi_m[win_num] ? ~mid_m : '1);
        else
            pend <= cand;
    end

    // Registered entry strobe, fault number and trap vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_enter <= 1'b0;
            fault_num   <= '0;
            trap_vec    <= '0;
        end else begin
            fault_enter <= win_valid;
            if (win_valid) begin
                fault_num <= win_num;
                trap_vec  <= {win_num, 1'b0};
            end
        end
    end

    // R10: an unassigned number never reaches the output.
    a_r10_unassigned_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fault_enter |-> (fr_pkg::fault_attr(int'(fault_num)).grp != 3'd0));

    // R9: group 7 entry only after an uninhibited pair completion.
    a_r9_g7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_enter && fr_pkg::fault_attr(int'(fault_num)).grp == 3'd7)
        |-> $past(pair_done && !g7_inhibit));

    // R5: groups 3 to 6 wait for the access acknowledge.
    a_r5_ack_before_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_enter && fr_pkg::fault_attr(int'(fault_num)).grp >= 3'd3
                     && fr_pkg::fault_attr(int'(fault_num)).grp <= 3'd6)
        |-> $past(mem_ack));

    // R6: group 4 waits for instruction completion.
    a_r6_g4_insn_done: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_enter && fr_pkg::fault_attr(int'(fault_num)).grp == 3'd4)
        |-> $past(insn_done));

    // R11: nothing is entered from inside the fault cycle.
    a_r11_not_in_fault_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fault_enter |-> ($past(cycle_kind) != 2'(fr_pkg::CYC_FAULT)));

    // R12: an entry needs a request or remembered fault.
    a_r12_entry_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        fault_enter |-> $past(|(fault_req | pend)));

    // R2: the trap vector follows the number on entry.
    a_r2_vector_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        fault_enter |=> $stable(trap_vec) || fault_enter);
endmodule

// File: tb/tb_fault_recog_ctrl.sv
`timescale 1ns/1ps
module tb_fault_recog_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fault_req;
    logic [1:0]  cycle_kind;
    logic        insn_done, pair_done, g7_inhibit, mem_ack;
    logic        fault_enter;
    logic [4:0]  fault_num;
    logic [5:0]  trap_vec;

    int   n_vec = 0;
    int   n_bad = 0;
    int   last  = 0;
    logic done_flag = 1'b0;

    always #4 clk = ~clk;

    fault_recog_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .cycle_kind(cycle_kind),
        .insn_done(insn_done), .pair_done(pair_done), .g7_inhibit(g7_inhibit),
        .mem_ack(mem_ack), .fault_enter(fault_enter), .fault_num(fault_num),
        .trap_vec(trap_vec)
    );

    // Priority order from R3, strongest first.
    localparam int ORDER [27] = '{12, 15, 31, 11, 7, 14, 13, 9, 5, 1, 2, 21, 22, 23,
                                  6, 10, 3, 24, 25, 16, 17, 18, 19, 20, 8, 4, 0};

    function automatic int rank(input int n);
        for (int k = 0; k < 27; k++) if (ORDER[k] == n) return k;
        return -1;
    endfunction

    // Group of a fault number as listed in R4 to R9.
    function automatic int grp(input int n);
        if (n == 12 || n == 15) return 1;
        if (n == 11 || n == 31) return 2;
        if (n == 13 || n == 14) return 3;
        if (n == 1 || n == 5 || n == 7 || n == 9) return 4;
        if (n == 2 || n == 3 || n == 6 || n == 10 || (n >= 21 && n <= 25)) return 5;
        if (n >= 16 && n <= 20) return 6;
        if (n == 0 || n == 4 || n == 8) return 7;
        return 0;
    endfunction

    // Compare outputs with the expected entry; num and vector hold otherwise.
    task automatic chk(input string tag, input logic exp_en, input int exp_num);
        n_vec++;
        if (exp_en) last = exp_num;
        if (fault_enter !== exp_en || fault_num !== 5'(last) || trap_vec !== 6'(2 * last)) begin
            n_bad++;
            $display("FAIL %s: actual en=%0b num=%0d vec=%0d expected en=%0b num=%0d vec=%0d",
                     tag, fault_enter, fault_num, trap_vec, exp_en, last, 2 * last);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic closed();
        fault_req = '0; cycle_kind = 2'd0; insn_done = 0; pair_done = 0;
        g7_inhibit = 0; mem_ack = 0;
    endtask

    task automatic all_open();
        cycle_kind = 2'd1; insn_done = 1; pair_done = 1; g7_inhibit = 0; mem_ack = 1;
    endtask

    initial begin
        closed();
        rst_n = 0;
        repeat (3) step();
        chk("R1 reset state", 0, 0);
        rst_n = 1;
        step();
        chk("R1 after release", 0, 0);

        // R4: groups 1 and 2 with every other condition closed.
        fault_req = 32'(1) << 12; step(); fault_req = '0;
        chk("R4 g1 immediate", 1, 12);
        step(); chk("R12 single entry", 0, 0);
        fault_req = 32'(1) << 31; step(); fault_req = '0;
        chk("R4 g2 immediate", 1, 31);

        // R5: group 3 waits for mem_ack.
        fault_req = 32'(1) << 13; step(); fault_req = '0;
        chk("R5 g3 held no ack", 0, 0);
        step(); chk("R5 g3 still held", 0, 0);
        mem_ack = 1; step(); mem_ack = 0;
        chk("R5 g3 on ack", 1, 13);

        // R6: group 4 needs both ack and instruction completion.
        fault_req = 32'(1) << 5; mem_ack = 1; step(); fault_req = '0;
        chk("R6 g4 ack only", 0, 0);
        mem_ack = 0; insn_done = 1; step();
        chk("R6 g4 done only", 0, 0);
        mem_ack = 1; step(); closed();
        chk("R6 g4 both", 1, 5);

        // R7: group 5 in execute needs no completion; group 6 in fetch does.
        fault_req = 32'(1) << 2; cycle_kind = 2'd1; mem_ack = 1; step(); closed();
        chk("R7 g5 during execute", 1, 2);
        fault_req = 32'(1) << 20; mem_ack = 1; step(); fault_req = '0;
        chk("R7 g6 fetch no done", 0, 0);
        mem_ack = 0; insn_done = 1; step();
        chk("R7 g6 no ack", 0, 0);
        mem_ack = 1; step(); closed();
        chk("R7 g6 done and ack", 1, 20);

        // R8: group 5 blocked by a waiting group 4, then discarded.
        fault_req = (32'(1) << 7) | (32'(1) << 3); cycle_kind = 2'd1; mem_ack = 1;
        step(); fault_req = '0;
        chk("R8 g5 blocked by g4", 0, 0);
        insn_done = 1; step();
        chk("R8 g4 taken", 1, 7);
        step(); chk("R8 g5 discarded", 0, 0);
        step(); chk("R8 g5 stays discarded", 0, 0);
        closed();

        // R9: group 7 held by inhibit and by missing pair completion.
        fault_req = 32'(1) << 4; pair_done = 1; g7_inhibit = 1; step(); fault_req = '0;
        chk("R9 g7 inhibited", 0, 0);
        pair_done = 0; g7_inhibit = 0; step();
        chk("R9 g7 no pair end", 0, 0);
        pair_done = 1; step(); closed();
        chk("R9 g7 taken", 1, 4);

        // R11: no entry during the fault cycle.
        fault_req = 32'(1) << 15; cycle_kind = 2'd2; all_open(); cycle_kind = 2'd2;
        step(); fault_req = '0;
        chk("R11 fault cycle blocks", 0, 0);
        step(); chk("R11 still blocked", 0, 0);
        cycle_kind = 2'd1; step(); closed();
        chk("R11 taken after fault cycle", 1, 15);

        // R10: unassigned numbers ignored even with all conditions open.
        all_open(); fault_req = 32'h7C00_0000; step(); fault_req = '0;
        chk("R10 unassigned no entry", 0, 0);
        step(); chk("R10 not remembered", 0, 0);
        fault_req = 32'h7C00_0001; step(); fault_req = '0;
        chk("R10 loses to group 7", 1, 0);
        step(); chk("R10 no follow-up", 0, 0);
        closed();

        // R1: reset discards a waiting fault.
        fault_req = 32'(1) << 14; step(); fault_req = '0;
        chk("R1 g3 waiting", 0, 0);
        rst_n = 0; step(); rst_n = 1; last = 0;
        chk("R1 reset clears outputs", 0, 0);
        mem_ack = 1; step();
        chk("R1 pending cleared", 0, 0);
        all_open(); step(); chk("R12 idle open", 0, 0);
        closed();

        // R3, R8, R10, R2: every pair of numbers, conditions open.
        all_open();
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 32; j++) begin
                int  w, l;
                logic ai, aj;
                ai = (grp(i) != 0); aj = (grp(j) != 0);
                w = -1; l = -1;
                if (ai && aj) begin
                    if (i == j) w = i;
                    else if (rank(i) < rank(j)) begin w = i; l = j; end
                    else begin w = j; l = i; end
                end else if (ai) w = i;
                else if (aj) w = j;
                if (l >= 0 && grp(w) <= 4 && (grp(l) == 5 || grp(l) == 6)) l = -1;
                fault_req = (32'(1) << i) | (32'(1) << j);
                step(); fault_req = '0;
                chk("R3 pair winner", w >= 0, (w >= 0) ? w : 0);
                step();
                chk("R8 pair follow-up", l >= 0, (l >= 0) ? l : 0);
                step();
                chk("R12 pair quiet", 0, 0);
            end
        end

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule